// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects 64 interrupt lines into two requests for a processor: a fast request and a normal request. Each line is brought into the clock domain and edge-detected. A rising edge latches a pending flag for that source. Software sets up the controller through a 32-bit register interface. For each source it sets an enable and a 3-bit level. It clears pending flags by writing ones to a status word.

The level of a source decides which request it feeds. Levels 0 and 1 feed the fast request. Levels 2 to 7 feed the normal request, and 7 is the weakest. For each request the block picks the strongest eligible pending source. It reports a vector entry for that source, equal to a programmable base plus four times the source number plus one. An entry of zero means that nothing is waiting. A one-bit mode register selects how enables act. In the default mode an enable gates arbitration, so clearing it hides a pending source at once. In the other mode the enable is sampled when the edge arrives, and a source that is already pending stays visible after it is disabled.

Top module: `prio_intc`

## Requirements
- R1: After reset, every pending flag and every enable is 0, every level field is 7 (each level word reads 0x77777777), the mode register reads 0, both requests are low and both entries are 0.
- R2: A rising edge on `src_i[k]` sets pending flag k. The flag can be seen three clock edges after the line rises. A line held high after its flag is cleared does not set the flag again.
- R3: Source k lives in bank k/32 at bit k%32. The fast status words are at 0x00 and 0x04 (banks 0 and 1). They show pending sources whose level is 0 or 1. The normal status words are at 0x08 and 0x0C and show the pending sources with levels 2 to 7. Writing 1 to a bit of a status word clears that pending flag if the source is routed to that word. Writing 0 has no effect.
- R4: The enable words at 0x18 (bank 0) and 0x1C (bank 1) read back exactly what was written.
- R5: The level words are at 0x30 + 4*r for r = 0..7. The level of source k is bits [4*(k%8)+2 : 4*(k%8)] of word k/8. Bit 3 of each nibble is dropped on write and reads 0.
- R6: A source at level 0 or 1 can only drive the fast request. A source at level 2 to 7 can only drive the normal request.
- R7: Among the eligible pending sources of one request, the lowest level wins. Between equal levels, the lower source number wins.
- R8: The entry of a request is base + 4*(k+1) for winner k, where the base is the word at 0x24. When no source is eligible, the request is low and the entry is 0.
- R9: With mode bit 0 (word 0x20) at 0, an edge always sets the pending flag. A source is eligible only while it is enabled, so clearing the enable removes it from arbitration in the same cycle the write takes effect.
- R10: With mode bit 0 at 1, an edge on a disabled source is discarded. A source that is already pending stays eligible after it is disabled.
- R11: When a rising edge and a write-1 clear of the same flag land on the same clock edge, the flag stays set.
- R12: The fast entry can be read at 0x10 and the normal entry at 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |
| fiq_entry | output | 32 | Entry of the fast winner, 0 when idle |
| irq_entry | output | 32 | Entry of the normal winner, 0 when idle |

## Verification
The bench sets up an edge and a software clear on the same clock edge. A design that let the clear win would lose an interrupt. It raises two sources at equal level: a wrong tie-break would report the higher number, and a wrong level compare would let a weak source hide a level-2 source from bank 1. It writes all ones to the fast status word while only normal-routed flags are pending, which catches a clear that ignores routing. It also toggles enables in both modes, which shows whether a disable hides a pending source at once or only stops new edges.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC      = 64;
    localparam int BANK_W       = 32;
    localparam int NUM_BANKS    = NUM_SRC / BANK_W;
    localparam int PRIO_W       = 3;
    localparam int NIBBLE_W     = 4;
    localparam int SRC_PER_WORD = BANK_W / NIBBLE_W;
    localparam int NUM_PWORDS   = NUM_SRC / SRC_PER_WORD;
    localparam int IDX_W        = $clog2(NUM_SRC);
    localparam int FAST_LEVELS  = 2;

    // word indices (byte address / 4)
    localparam int W_FSTAT = 0;
    localparam int W_NSTAT = 2;
    localparam int W_FENT  = 4;
    localparam int W_NENT  = 5;
    localparam int W_EN    = 6;
    localparam int W_MODE  = 8;
    localparam int W_BASE  = 9;
    localparam int W_LEVEL = 12;

    typedef logic [PRIO_W-1:0] level_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        level_t           level;
    } winner_t;

    function automatic logic is_fast(level_t lv);
        return lv < level_t'(FAST_LEVELS);
    endfunction

    function automatic logic [31:0] entry_of(logic [31:0] base, logic [IDX_W-1:0] idx);
        return base + ((32'(idx) + 32'd1) << 2);
    endfunction
endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter bit FAST = 1'b1
) (
    input  logic                 latched_mode,
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0]         en_i,
    input  level_t [N-1:0]       level_i,
    output winner_t              win_o
);
    logic [N-1:0] eligible;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            eligible[i] = pend_i[i] && (latched_mode || en_i[i]) &&
                          (is_fast(level_i[i]) == FAST);
        end
    end

    always_comb begin
        win_o = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && (!win_o.valid || level_i[i] < win_o.level)) begin
                win_o.valid = 1'b1;
                win_o.idx   = IDX_W'(i);
                win_o.level = level_i[i];
            end
        end
    end
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [7:0]           addr,
    input  logic [31:0]          wdata,
    input  logic [NUM_SRC-1:0]   rise_i,
    input  logic [31:0]          fast_entry_i,
    input  logic [31:0]          norm_entry_i,
    output logic [31:0]          rdata,
    output logic [NUM_SRC-1:0]   pend_q,
    output logic [NUM_SRC-1:0]   en_q,
    output level_t [NUM_SRC-1:0] level_q,
    output logic                 mode_q,
    output logic [31:0]          base_q,
    output logic [NUM_SRC-1:0]   set_vec
);
    logic [5:0]         widx;
    logic [NUM_SRC-1:0] fast_map;
    logic [NUM_SRC-1:0] clr_vec;

    assign widx = addr[7:2];

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) fast_map[i] = is_fast(level_q[i]);
    end

    always_comb begin
        clr_vec = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (we && widx == 6'(W_FSTAT + b))
                clr_vec[b*BANK_W +: BANK_W] = wdata & fast_map[b*BANK_W +: BANK_W];
            if (we && widx == 6'(W_NSTAT + b))
                clr_vec[b*BANK_W +: BANK_W] = wdata & ~fast_map[b*BANK_W +: BANK_W];
        end
    end

    assign set_vec = rise_i & (mode_q ? en_q : '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            mode_q <= 1'b0;
            base_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) level_q[i] <= '1;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
            if (we) begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (widx == 6'(W_EN + b)) en_q[b*BANK_W +: BANK_W] <= wdata;
                for (int r = 0; r < NUM_PWORDS; r++)
                    if (widx == 6'(W_LEVEL + r))
                        for (int f = 0; f < SRC_PER_WORD; f++)
                            level_q[r*SRC_PER_WORD + f] <= wdata[f*NIBBLE_W +: PRIO_W];
                if (widx == 6'(W_MODE)) mode_q <= wdata[0];
                if (widx == 6'(W_BASE)) base_q <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (widx == 6'(W_FSTAT + b))
                rdata = pend_q[b*BANK_W +: BANK_W] & fast_map[b*BANK_W +: BANK_W];
            if (widx == 6'(W_NSTAT + b))
                rdata = pend_q[b*BANK_W +: BANK_W] & ~fast_map[b*BANK_W +: BANK_W];
            if (widx == 6'(W_EN + b))
                rdata = en_q[b*BANK_W +: BANK_W];
        end
        for (int r = 0; r < NUM_PWORDS; r++)
            if (widx == 6'(W_LEVEL + r))
                for (int f = 0; f < SRC_PER_WORD; f++)
                    rdata[f*NIBBLE_W +: NIBBLE_W] = {1'b0, level_q[r*SRC_PER_WORD + f]};
        if (widx == 6'(W_FENT)) rdata = fast_entry_i;
        if (widx == 6'(W_NENT)) rdata = norm_entry_i;
        if (widx == 6'(W_MODE)) rdata = {31'd0, mode_q};
        if (widx == 6'(W_BASE)) rdata = base_q;
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                fiq_req,
    output logic                irq_req,
    output logic [31:0]         fiq_entry,
    output logic [31:0]         irq_entry
);
    logic [NUM_SRC-1:0]   rise_vec;
    logic [NUM_SRC-1:0]   pend_q, en_q, set_vec;
    level_t [NUM_SRC-1:0] level_q;
    logic                 mode_q;
    logic [31:0]          base_q;
    winner_t              win [2];
    logic [IDX_W-1:0]     fiq_idx, irq_idx;

    pic_edge_det #(.N(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (src_i),
        .rise_o (rise_vec)
    );

    pic_regfile u_regs (
        .clk          (clk),
        .rst          (rst),
        .we           (bus_we),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .rise_i       (rise_vec),
        .fast_entry_i (fiq_entry),
        .norm_entry_i (irq_entry),
        .rdata        (bus_rdata),
        .pend_q       (pend_q),
        .en_q         (en_q),
        .level_q      (level_q),
        .mode_q       (mode_q),
        .base_q       (base_q),
        .set_vec      (set_vec)
    );

    // output 0 is the fast request, output 1 the normal request
    for (genvar g = 0; g < 2; g++) begin : g_arb
        pic_arbiter #(.N(NUM_SRC), .FAST(g == 0)) u_arb (
            .latched_mode (mode_q),
            .pend_i       (pend_q),
            .en_i         (en_q),
            .level_i      (level_q),
            .win_o        (win[g])
        );
    end

    assign fiq_req   = win[0].valid;
    assign irq_req   = win[1].valid;
    assign fiq_idx   = win[0].idx;
    assign irq_idx   = win[1].idx;
    assign fiq_entry = win[0].valid ? entry_of(base_q, win[0].idx) : 32'd0;
    assign irq_entry = win[1].valid ? entry_of(base_q, win[1].idx) : 32'd0;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 fiq_req,
    input logic                 irq_req,
    input logic [31:0]          fiq_entry,
    input logic [31:0]          irq_entry,
    input logic [IDX_W-1:0]     fiq_idx,
    input logic [IDX_W-1:0]     irq_idx,
    input logic [NUM_SRC-1:0]   pend_q,
    input logic [NUM_SRC-1:0]   en_q,
    input logic [NUM_SRC-1:0]   set_vec,
    input level_t [NUM_SRC-1:0] level_q,
    input logic                 mode_q
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0 && en_q == '0 && !fiq_req && !irq_req));

    p_fiq_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !fiq_req |-> fiq_entry == 32'd0);

    p_irq_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> irq_entry == 32'd0);

    p_fiq_fast_level_r6: assert property (@(posedge clk) disable iff (rst)
        fiq_req |-> level_q[fiq_idx] < level_t'(FAST_LEVELS));

    p_irq_slow_level_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> level_q[irq_idx] >= level_t'(FAST_LEVELS));

    p_mask_now_r9: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && irq_req) |-> en_q[irq_idx]);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
endmodule

bind prio_intc pic_checker u_pic_checker (
    .clk       (clk),
    .rst       (rst),
    .fiq_req   (fiq_req),
    .irq_req   (irq_req),
    .fiq_entry (fiq_entry),
    .irq_entry (irq_entry),
    .fiq_idx   (fiq_idx),
    .irq_idx   (irq_idx),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .set_vec   (set_vec),
    .level_q   (level_q),
    .mode_q    (mode_q)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_req, irq_req;
    logic [31:0] fiq_entry, irq_entry;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fiq_req(fiq_req), .irq_req(irq_req),
        .fiq_entry(fiq_entry), .irq_entry(irq_entry)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int k);
        src_i[k] = 1'b1;
        tick(1);
        src_i[k] = 1'b0;
        tick(4);
    endtask

    task automatic clear_all();
        wr(8'h00, '1); wr(8'h04, '1); wr(8'h08, '1); wr(8'h0C, '1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h18, d); chk("R1 enable bank0", d, 0);
        rd(8'h1C, d); chk("R1 enable bank1", d, 0);
        rd(8'h08, d); chk("R1 pending", d, 0);
        rd(8'h30, d); chk("R1 level word0", d, 32'h7777_7777);
        rd(8'h4C, d); chk("R1 level word7", d, 32'h7777_7777);
        rd(8'h20, d); chk("R1 mode", d, 0);
        chk("R1 requests", {30'd0, fiq_req, irq_req}, 0);
        chk("R1 entries", fiq_entry | irq_entry, 0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        wr(8'h18, 32'hA5A5_0F0F); wr(8'h1C, 32'h1234_5678);
        rd(8'h18, d); chk("R4 enable bank0", d, 32'hA5A5_0F0F);
        rd(8'h1C, d); chk("R4 enable bank1", d, 32'h1234_5678);
        wr(8'h18, 0); wr(8'h1C, 0);
    endtask

    task automatic t_level_pack();
        logic [31:0] d;
        wr(8'h34, 32'hF8E9_DACB);
        rd(8'h34, d); chk("R5 nibble bit3 dropped", d, 32'h7061_5243);
        rd(8'h30, d); chk("R5 other word untouched", d, 32'h7777_7777);
        wr(8'h34, 32'h7777_7777);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        pulse(5); pulse(40);
        rd(8'h08, d); chk("R2 R3 bank0 bit5", d, 32'h0000_0020);
        rd(8'h0C, d); chk("R3 bank1 bit8 for src40", d, 32'h0000_0100);
        rd(8'h00, d); chk("R3 fast status empty", d, 0);
        chk("R9 disabled no req", {31'd0, irq_req}, 0);
        wr(8'h18, 32'h0000_0020);
        chk("R8 irq entry src5", irq_entry, 32'd24);
        chk("R8 irq req", {31'd0, irq_req}, 1);
        wr(8'h08, 32'h0);
        rd(8'h08, d); chk("R3 write zero no effect", d, 32'h0000_0020);
        wr(8'h00, '1);
        rd(8'h08, d); chk("R3 fast clear ignores slow src", d, 32'h0000_0020);
        wr(8'h08, 32'h0000_0020);
        rd(8'h08, d); chk("R3 cleared", d, 0);
        chk("R8 idle entry", irq_entry, 0);
        chk("R8 idle req", {31'd0, irq_req}, 0);
        src_i[5] = 1'b1; tick(5);
        rd(8'h08, d); chk("R2 held line sets once", d, 32'h0000_0020);
        wr(8'h08, 32'h0000_0020); tick(4);
        rd(8'h08, d); chk("R2 held level no retrigger", d, 0);
        src_i[5] = 1'b0; tick(3);
        clear_all();
        wr(8'h18, 0);
    endtask

    task automatic t_arbitrate();
        logic [31:0] d;
        wr(8'h30, 32'h7777_1777);
        wr(8'h34, 32'h7774_7477);
        wr(8'h48, 32'h7777_7277);
        wr(8'h18, '1); wr(8'h1C, '1);
        wr(8'h24, 32'h0000_1000);
        pulse(12); pulse(10);
        chk("R7 tie lower number", irq_entry, 32'h102C);
        pulse(50);
        chk("R7 lower level wins", irq_entry, 32'h10CC);
        chk("R6 no fast yet", {31'd0, fiq_req}, 0);
        pulse(3);
        chk("R6 fast req", {31'd0, fiq_req}, 1);
        chk("R8 fast entry", fiq_entry, 32'h1010);
        chk("R6 normal unchanged", irq_entry, 32'h10CC);
        rd(8'h00, d); chk("R3 fast status bit3", d, 32'h0000_0008);
        rd(8'h10, d); chk("R12 fast entry read", d, 32'h1010);
        rd(8'h14, d); chk("R12 normal entry read", d, 32'h10CC);
        wr(8'h0C, 32'h0004_0000);
        chk("R3 R7 after clear src50", irq_entry, 32'h102C);
        wr(8'h00, 32'h0000_0008);
        chk("R3 fast cleared", {31'd0, fiq_req}, 0);
        wr(8'h18, 32'hFFFF_FBFF);
        chk("R9 disable masks now", irq_entry, 32'h1034);
        wr(8'h18, '1);
        chk("R9 reenable", irq_entry, 32'h102C);
        clear_all();
        wr(8'h30, 32'h7777_7777); wr(8'h34, 32'h7777_7777); wr(8'h48, 32'h7777_7777);
        wr(8'h18, 0); wr(8'h1C, 0); wr(8'h24, 0);
    endtask

    task automatic t_latched_mode();
        logic [31:0] d;
        wr(8'h20, 1);
        rd(8'h20, d); chk("R10 mode readback", d, 1);
        pulse(7);
        rd(8'h08, d); chk("R10 edge on disabled dropped", d, 0);
        wr(8'h18, 32'h0000_0080);
        pulse(7);
        chk("R10 enabled edge", irq_entry, 32'd32);
        wr(8'h18, 0);
        chk("R10 stays after disable", {31'd0, irq_req}, 1);
        clear_all();
        wr(8'h20, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        src_i[20] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(8'h08, 32'h0010_0000);
        rd(8'h08, d); chk("R11 edge beats clear", d, 32'h0010_0000);
        src_i[20] = 1'b0; tick(3);
        wr(8'h08, 32'h0010_0000);
        rd(8'h08, d); chk("R11 plain clear works", d, 0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_enable_rw();
        t_level_pack();
        t_pending();
        t_arbitrate();
        t_latched_mode();
        t_race();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule